// File: doc/BRIEF.md
# Narrow-Lane Packet Memory Bus Controller

This block sits on the controller side of a memory interface with three narrow, separate lanes. A row lane 3 bits wide, a column lane 5 bits wide and a data lane 16 bits wide each carry fixed-length packets of eight beats. Every packet spends four clock cycles on its lane. The physical interface moves one beat on each clock edge. Here that edge pair is modelled as two beats per rising edge, so each lane output is twice the lane width. The earlier beat of the pair sits in the upper half.

The requester hands over a whole packet word on each lane through that lane's own valid/ready handshake. The packet words are 24 bits for a row, 40 bits for a column and 128 bits for data. Command or bank fields live above the address bits, and unused bits are sent as zero. Because the lanes are independent, row, column and data packets can overlap in time. A packet may follow the previous one on the same lane without a gap.

On the receive side, read data arrives as beat pairs on the data lane. Eight beats are assembled into one 128-bit word. The data lane width is a parameter: setting it to 18 gives 144-bit packets for an error-correcting data path.

Top module: `pkt_lane_ctrl`

## Requirements
- R1: During and right after reset, every transmit lane has its activity flag low, its pair output zero and its ready high. The read word valid flag is low.
- R2: A packet is eight beats of lane width, sent over four cycles at two beats per cycle. This gives packet words of 24 bits (row), 40 bits (column) and 128 bits (data).
- R3: Beats go out most significant chunk first. In the c-th cycle of a packet (c = 0..3), the lane pair output equals bits [P-1-2Wc : P-2W(c+1)] of the P-bit packet word, where W is the lane width. The upper W bits of the pair are the earlier beat.
- R4: A packet word is taken on a rising edge where valid and ready are both high. The activity flag is high for exactly the four following cycles, and the first pair appears in the cycle after acceptance.
- R5: Ready is high when the lane is idle and in the last cycle of a packet, and low otherwise. A word taken in the last cycle follows the previous packet with no idle cycle.
- R6: The three transmit lanes run independently. Packets on different lanes may be active in the same cycles.
- R7: An idle lane drives an all-zero pair output and a low activity flag. A valid that is not accepted leaves the lane idle.
- R8: Receive pairs are taken on rising edges where the read-beat flag is high, with the upper half as the earlier beat. After four pairs, the read word valid flag is high for one cycle, the cycle after the fourth pair. The read word then holds the eight beats, first beat in the most significant bits.
- R9: Cycles with the read-beat flag low are ignored. A partly assembled word keeps its beats and continues when pairs resume.
- R10: The read word output keeps its value until the next word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two beats per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_vld | input | 1 | Row packet word offered |
| row_pkt | input | 24 | Row packet word |
| row_rdy | output | 1 | Row lane can take a word |
| col_vld | input | 1 | Column packet word offered |
| col_pkt | input | 40 | Column packet word |
| col_rdy | output | 1 | Column lane can take a word |
| dat_vld | input | 1 | Write data packet word offered |
| dat_pkt | input | 128 | Write data packet word |
| dat_rdy | output | 1 | Data lane can take a word |
| row_pair | output | 6 | Row lane beat pair, earlier beat on top |
| row_act | output | 1 | Row lane sending |
| col_pair | output | 10 | Column lane beat pair |
| col_act | output | 1 | Column lane sending |
| dat_pair | output | 32 | Data lane beat pair |
| dat_act | output | 1 | Data lane sending |
| rd_act | input | 1 | Read beat pair present this cycle |
| rd_pair | input | 32 | Read beat pair, earlier beat on top |
| rd_word | output | 128 | Assembled read word |
| rd_vld | output | 1 | One-cycle pulse when rd_word is new |

## Verification
The bench builds the block with its default values: lanes 3, 5 and 16 bits wide and eight beats per packet. This gives pair outputs that are 6, 10 and 32 bits wide. The 32-bit data pair exercises the full-width mask edge case, and the three different lane widths expose any slice offset error. A phase with valid held high on all lanes covers back-to-back packets and overlap between lanes. Random phases with gapped read beats cover partial assembly across idle cycles.

// File: rtl/pkt_lane_pkg.sv
package pkt_lane_pkg;
  localparam int unsigned BEATS_PER_CLK = 2;

  typedef enum logic {LANE_IDLE = 1'b0, LANE_SEND = 1'b1} lane_st_e;

  function automatic int unsigned clocks_per_pkt(input int unsigned beats);
    return beats / BEATS_PER_CLK;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned beats);
    return (clocks_per_pkt(beats) > 1) ? $clog2(clocks_per_pkt(beats)) : 1;
  endfunction
endpackage

// File: rtl/pkt_lane_tx.sv
module pkt_lane_tx
  import pkt_lane_pkg::*;
#(
  parameter int unsigned LANE_W = 3,
  parameter int unsigned BEATS  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic [LANE_W*BEATS-1:0]    in_word,
  output logic                       in_rdy,
  output logic [2*LANE_W-1:0]        out_pair,
  output logic                       out_act,
  output logic                       ev_take,
  output logic                       ev_last
);
  localparam int unsigned PKT_W  = LANE_W * BEATS;
  localparam int unsigned PAIR_W = LANE_W * BEATS_PER_CLK;
  localparam int unsigned NCLK   = clocks_per_pkt(BEATS);
  localparam int unsigned CW     = cnt_width(BEATS);
  localparam logic [CW-1:0] LAST_CNT = CW'(NCLK - 1);

  function automatic logic [PAIR_W-1:0] lead_pair(input logic [PKT_W-1:0] w);
    return w[PKT_W-1 -: PAIR_W];
  endfunction

  lane_st_e          st_q;
  logic [CW-1:0]     cnt_q;
  logic [PKT_W-1:0]  shreg_q;

  assign ev_last  = (st_q == LANE_SEND) && (cnt_q == LAST_CNT);
  assign in_rdy   = (st_q == LANE_IDLE) || ev_last;
  assign ev_take  = in_vld && in_rdy;
  assign out_act  = (st_q == LANE_SEND);
  assign out_pair = out_act ? lead_pair(shreg_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= LANE_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (ev_take) begin
      st_q    <= LANE_SEND;
      cnt_q   <= '0;
      shreg_q <= in_word;
    end else if (st_q == LANE_SEND) begin
      shreg_q <= shreg_q << PAIR_W;
      if (ev_last) begin
        st_q  <= LANE_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_lane_rx.sv
module pkt_lane_rx
  import pkt_lane_pkg::*;
#(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned BEATS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat_act,
  input  logic [2*LANE_W-1:0]      pair,
  output logic [LANE_W*BEATS-1:0]  word,
  output logic                     word_vld,
  output logic                     ev_fill
);
  localparam int unsigned PKT_W  = LANE_W * BEATS;
  localparam int unsigned PAIR_W = LANE_W * BEATS_PER_CLK;
  localparam int unsigned NCLK   = clocks_per_pkt(BEATS);
  localparam int unsigned CW     = cnt_width(BEATS);
  localparam logic [CW-1:0] LAST_CNT = CW'(NCLK - 1);

  function automatic logic [PKT_W-1:0] append_pair(input logic [PKT_W-1:0] acc,
                                                   input logic [PAIR_W-1:0] p);
    return {acc[PKT_W-PAIR_W-1:0], p};
  endfunction

  logic [CW-1:0]    cnt_q;
  logic [PKT_W-1:0] acc_q;

  assign ev_fill = beat_act && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (beat_act) begin
        acc_q <= append_pair(acc_q, pair);
        if (ev_fill) begin
          cnt_q    <= '0;
          word     <= append_pair(acc_q, pair);
          word_vld <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_lane_ctrl.sv
module pkt_lane_ctrl
  import pkt_lane_pkg::*;
#(
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BEATS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     row_vld,
  input  logic [ROW_W*BEATS-1:0]   row_pkt,
  output logic                     row_rdy,
  input  logic                     col_vld,
  input  logic [COL_W*BEATS-1:0]   col_pkt,
  output logic                     col_rdy,
  input  logic                     dat_vld,
  input  logic [DATA_W*BEATS-1:0]  dat_pkt,
  output logic                     dat_rdy,
  output logic [2*ROW_W-1:0]       row_pair,
  output logic                     row_act,
  output logic [2*COL_W-1:0]       col_pair,
  output logic                     col_act,
  output logic [2*DATA_W-1:0]      dat_pair,
  output logic                     dat_act,
  input  logic                     rd_act,
  input  logic [2*DATA_W-1:0]      rd_pair,
  output logic [DATA_W*BEATS-1:0]  rd_word,
  output logic                     rd_vld
);
  logic row_take, row_last, col_take, col_last, dat_take, dat_last, rd_fill;

  pkt_lane_tx #(.LANE_W(ROW_W), .BEATS(BEATS)) u_row (
    .clk(clk), .rst_n(rst_n), .in_vld(row_vld), .in_word(row_pkt), .in_rdy(row_rdy),
    .out_pair(row_pair), .out_act(row_act), .ev_take(row_take), .ev_last(row_last));

  pkt_lane_tx #(.LANE_W(COL_W), .BEATS(BEATS)) u_col (
    .clk(clk), .rst_n(rst_n), .in_vld(col_vld), .in_word(col_pkt), .in_rdy(col_rdy),
    .out_pair(col_pair), .out_act(col_act), .ev_take(col_take), .ev_last(col_last));

  pkt_lane_tx #(.LANE_W(DATA_W), .BEATS(BEATS)) u_dat (
    .clk(clk), .rst_n(rst_n), .in_vld(dat_vld), .in_word(dat_pkt), .in_rdy(dat_rdy),
    .out_pair(dat_pair), .out_act(dat_act), .ev_take(dat_take), .ev_last(dat_last));

  pkt_lane_rx #(.LANE_W(DATA_W), .BEATS(BEATS)) u_rd (
    .clk(clk), .rst_n(rst_n), .beat_act(rd_act), .pair(rd_pair),
    .word(rd_word), .word_vld(rd_vld), .ev_fill(rd_fill));
endmodule

// File: rtl/pkt_lane_ctrl_chk.sv
module pkt_lane_ctrl_chk
  import pkt_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BEATS  = 8
) (
  input logic clk, rst_n,
  input logic row_vld, row_rdy, row_act, row_take, row_last,
  input logic col_vld, col_rdy, col_act, col_take, col_last,
  input logic dat_vld, dat_rdy, dat_act, dat_take, dat_last,
  input logic rd_act, rd_vld, rd_fill,
  input logic [DATA_W*BEATS-1:0] rd_word
);
  localparam int unsigned NCLK = clocks_per_pkt(BEATS);
  localparam int unsigned CW   = cnt_width(BEATS);
  localparam logic [CW-1:0] LAST_CNT = CW'(NCLK - 1);

  logic [CW-1:0] row_run, col_run, dat_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_run <= '0; col_run <= '0; dat_run <= '0;
    end else begin
      if (row_act) row_run <= (row_run == LAST_CNT) ? '0 : row_run + 1'b1;
      if (col_act) col_run <= (col_run == LAST_CNT) ? '0 : col_run + 1'b1;
      if (dat_act) dat_run <= (dat_run == LAST_CNT) ? '0 : dat_run + 1'b1;
    end
  end

  // R4
  row_take_act_chk: assert property (@(posedge clk) disable iff (!rst_n) row_take |=> row_act);
  // R4
  col_take_act_chk: assert property (@(posedge clk) disable iff (!rst_n) col_take |=> col_act);
  // R4
  dat_take_act_chk: assert property (@(posedge clk) disable iff (!rst_n) dat_take |=> dat_act);
  // R2
  row_whole_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n) !row_act |-> row_run == '0);
  // R2
  col_whole_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n) !col_act |-> col_run == '0);
  // R2
  dat_whole_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n) !dat_act |-> dat_run == '0);
  // R5
  row_busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && row_run != LAST_CNT) |-> !row_rdy);
  // R5
  col_busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_act && col_run != LAST_CNT) |-> !col_rdy);
  // R5
  dat_busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_act && dat_run != LAST_CNT) |-> !dat_rdy);
  // R5
  row_last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) row_last |-> row_run == LAST_CNT);
  // R5
  col_last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) col_last |-> col_run == LAST_CNT);
  // R5
  dat_last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) dat_last |-> dat_run == LAST_CNT);
  // R7
  row_idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rdy && !row_vld) |=> !row_act);
  // R7
  col_idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_rdy && !col_vld) |=> !col_act);
  // R7
  dat_idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rdy && !dat_vld) |=> !dat_act);
  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_vld |=> !rd_vld);
  // R8
  rd_fill_vld_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_fill |=> rd_vld);
  // R9
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_act |=> !rd_vld);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_fill |=> $stable(rd_word));
endmodule

bind pkt_lane_ctrl pkt_lane_ctrl_chk #(.DATA_W(DATA_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .row_vld(row_vld), .row_rdy(row_rdy), .row_act(row_act), .row_take(row_take), .row_last(row_last),
  .col_vld(col_vld), .col_rdy(col_rdy), .col_act(col_act), .col_take(col_take), .col_last(col_last),
  .dat_vld(dat_vld), .dat_rdy(dat_rdy), .dat_act(dat_act), .dat_take(dat_take), .dat_last(dat_last),
  .rd_act(rd_act), .rd_vld(rd_vld), .rd_fill(rd_fill), .rd_word(rd_word));

// File: tb/pkt_lane_ctrl_bench.sv
module pkt_lane_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int BEATS  = 8;
  localparam int NCLK   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_vld = 0, col_vld = 0, dat_vld = 0, rd_act = 0;
  logic [23:0]  row_pkt = '0;
  logic [39:0]  col_pkt = '0;
  logic [127:0] dat_pkt = '0;
  logic [31:0]  rd_pair = '0;
  logic row_rdy, col_rdy, dat_rdy, row_act, col_act, dat_act, rd_vld;
  logic [5:0]   row_pair;
  logic [9:0]   col_pair;
  logic [31:0]  dat_pair;
  logic [127:0] rd_word;

  int checks = 0;
  int errors = 0;

  pkt_lane_ctrl u_pkt_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .row_vld(row_vld), .row_pkt(row_pkt), .row_rdy(row_rdy),
    .col_vld(col_vld), .col_pkt(col_pkt), .col_rdy(col_rdy),
    .dat_vld(dat_vld), .dat_pkt(dat_pkt), .dat_rdy(dat_rdy),
    .row_pair(row_pair), .row_act(row_act),
    .col_pair(col_pair), .col_act(col_act),
    .dat_pair(dat_pair), .dat_act(dat_act),
    .rd_act(rd_act), .rd_pair(rd_pair), .rd_word(rd_word), .rd_vld(rd_vld));

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] lane_mask(input int bits);
    return (bits >= 128) ? {128{1'b1}} : ((128'h1 << bits) - 128'h1);
  endfunction

  // Pair sent in cycle c: bits counted down from the top of the packet word.
  function automatic logic [31:0] exp_pair(input logic [127:0] w, input int lw, input int c);
    logic [127:0] t;
    t = w >> (lw * BEATS - 2 * lw * (c + 1));
    return 32'(t & lane_mask(2 * lw));
  endfunction

  int           lw [3] = '{3, 5, 16};
  logic [127:0] m_word [3];
  int           m_cyc [3];
  logic [127:0] acc;
  logic [127:0] exp_rword;
  int           rcnt;
  logic         exp_rvld;
  int           overlap_seen;

  task automatic one_cycle(input int tx_mode, input int rx_pct);
    logic [31:0] a_pair;
    logic        a_act, a_rdy, e_act, e_rdy;
    logic        vld [3];
    logic [127:0] wd [3];
    @(negedge clk);
    for (int l = 0; l < 3; l++) begin
      case (l)
        0: begin a_pair = 32'(row_pair); a_act = row_act; a_rdy = row_rdy; end
        1: begin a_pair = 32'(col_pair); a_act = col_act; a_rdy = col_rdy; end
        default: begin a_pair = dat_pair; a_act = dat_act; a_rdy = dat_rdy; end
      endcase
      e_act = (m_cyc[l] >= 0);
      e_rdy = (m_cyc[l] < 0) || (m_cyc[l] == NCLK - 1);
      check("R4", $sformatf("lane%0d act", l), 128'(a_act), 128'(e_act));
      check("R5", $sformatf("lane%0d rdy", l), 128'(a_rdy), 128'(e_rdy));
      if (e_act) check("R3", $sformatf("lane%0d pair c%0d", l, m_cyc[l]), 128'(a_pair),
                       128'(exp_pair(m_word[l], lw[l], m_cyc[l])));
      else       check("R7", $sformatf("lane%0d idle pair", l), 128'(a_pair), 128'(0));
      vld[l] = (tx_mode == 0) ? 1'b1 : (tx_mode == 1) ? ($urandom % 3 == 0) : 1'b0;
      wd[l]  = {$urandom, $urandom, $urandom, $urandom} & lane_mask(lw[l] * BEATS);
      if (m_cyc[l] >= 0) m_cyc[l] = (m_cyc[l] == NCLK - 1) ? -1 : m_cyc[l] + 1;
      if (vld[l] && e_rdy) begin m_word[l] = wd[l]; m_cyc[l] = 0; end
    end
    if (row_act && col_act && dat_act) overlap_seen++;
    // receive side
    check("R8", "rd_vld", 128'(rd_vld), 128'(exp_rvld));
    if (exp_rvld) check("R8", "rd_word", rd_word, exp_rword);
    else          check("R10", "rd_word held", rd_word, exp_rword);
    row_vld = vld[0]; row_pkt = wd[0][23:0];
    col_vld = vld[1]; col_pkt = wd[1][39:0];
    dat_vld = vld[2]; dat_pkt = wd[2];
    rd_act  = ($urandom % 100) < rx_pct;
    rd_pair = $urandom;
    exp_rvld = 1'b0;
    if (rd_act) begin
      acc = {acc[95:0], rd_pair};
      rcnt++;
      if (rcnt == NCLK) begin exp_rvld = 1'b1; exp_rword = acc; rcnt = 0; end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < 3; l++) begin m_cyc[l] = -1; m_word[l] = '0; end
    acc = '0; exp_rword = '0; rcnt = 0; exp_rvld = 1'b0; overlap_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "row_rdy", 128'(row_rdy), 128'(1));
    check("R1", "col_rdy", 128'(col_rdy), 128'(1));
    check("R1", "dat_rdy", 128'(dat_rdy), 128'(1));
    check("R1", "acts", 128'({row_act, col_act, dat_act}), 128'(0));
    check("R1", "pairs", 128'({row_pair, col_pair, dat_pair}), 128'(0));
    check("R1", "rd_vld", 128'(rd_vld), 128'(0));
    rst_n = 1'b1;
    // Directed: all lanes streaming back to back (R5, R6), read beats without gaps (R8)
    for (int i = 0; i < 40; i++) one_cycle(0, 100);
    check("R6", "lanes active together", 128'(overlap_seen > 0), 128'(1));
    // Random offers on every lane, gapped read beats (R9)
    for (int i = 0; i < 600; i++) one_cycle(1, 40);
    // Idle drain: no offers, no read beats (R7, R10)
    for (int i = 0; i < 12; i++) one_cycle(2, 0);
    // Sparse read beats across long gaps (R9)
    for (int i = 0; i < 60; i++) one_cycle(1, 10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule